// File: doc/BRIEF.md
# Configurable Interrupt Request Front End

This block sits between the raw interrupt pins of a processor core and its priority resolver. It takes one non-maskable request pin and a set of maskable request pins, default four. It synchronizes each of them to the core clock and turns them into clean pending flags that the resolver can sample in any cycle.

The non-maskable pin is edge-sensitive only. A rising edge marks it pending. The core takes that request, with a fixed vector type, on the next cycle in which it signals an instruction boundary. Taking it clears the flag, and the flag stays clear until the pin falls and rises again.

Each maskable line is set to edge or level operation by a configuration bit. The two highest lines can be turned around to act as active-low acknowledge outputs for the two lowest lines. In that case their request function is suppressed, and the block drives the acknowledge strobe when the paired low line is acknowledged.

Top module: `irq_front_end`

## Requirements
- R1: Every pin passes through SYNC_STAGES (default 2) flip-flops. A level-mode line's pending flag is high from the second rising clock edge after its pin goes high. An edge-mode line's flag is still low at that point.
- R2: A rising edge on `nmi_pin` sets `nmi_pending` at the third rising clock edge after the pin goes high. A high pulse lasting a single clock period is enough to set it.
- R3: `nmi_take` is high, with `nmi_vector` equal to 2, only in a cycle where `boundary` is high and `nmi_pending` is set. `nmi_pending` is clear after that edge. Holding `nmi_pin` high does not set it again. `cfg_level` and `cfg_ack_out` have no effect on this path.
- R4: With `cfg_level[i]`=1 (level mode), `irq_pending[i]` follows the synchronized pin. A request that falls before it is acknowledged is lost.
- R5: With `cfg_level[i]`=0 (edge mode), a synchronized rising edge sets `irq_pending[i]` one edge after the level path would show it. The flag stays set after the pin falls. It clears at the edge that samples `ack_valid`=1 with `ack_idx`=i.
- R6: An acknowledge whose `ack_idx` names a different line leaves an edge-mode pending flag set.
- R7: If a new rising edge and the matching acknowledge arrive at the same clock edge, the edge-mode flag stays set.
- R8: With `cfg_ack_out[k]`=1, line k+2 is an acknowledge output. Its `irq_pending` bit is 0, its pin is ignored (an edge seen meanwhile is not remembered), and `ack_oe[k]` is 1.
- R9: `ack_n[k]` is low for exactly the one cycle after an edge that samples `ack_valid`=1, `ack_idx`=k and `cfg_ack_out[k]`=1. In every other cycle it is high.
- R10: While `rst_n` is low, all pending flags and `nmi_take` are 0 and `ack_n` is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| nmi_pin | input | 1 | Raw non-maskable request pin |
| irq_pin | input | NUM_IRQ | Raw maskable request pins, active high |
| cfg_level | input | NUM_IRQ | Per line: 1 = level mode, 0 = edge mode |
| cfg_ack_out | input | ACK_LINES | Per bit k: line k+2 becomes the acknowledge output for line k |
| boundary | input | 1 | Instruction boundary strobe from the core |
| ack_valid | input | 1 | Interrupt acknowledge strobe |
| ack_idx | input | $clog2(NUM_IRQ) | Index of the line being acknowledged |
| nmi_pending | output | 1 | Non-maskable request is waiting |
| nmi_take | output | 1 | Non-maskable request is taken this cycle |
| nmi_vector | output | VEC_W | Vector type while nmi_take is high, else 0 |
| irq_pending | output | NUM_IRQ | Pending flag per maskable line |
| ack_n | output | ACK_LINES | Active-low acknowledge pulses for the repurposed pins |
| ack_oe | output | ACK_LINES | Output enable for the repurposed pins |

## Verification
The bench sweeps every line through both trigger modes. It samples one edge before and one edge after the expected arrival of each flag, so a synchronizer with a stage too many or too few shows up as a flag that comes a cycle early or late. Edge-mode flags are tested against a pin that falls before acknowledge, an acknowledge to the wrong index, and an acknowledge that coincides with a fresh rising edge. A design that clears on any acknowledge, or lets the clear win, drops a request there. The non-maskable path is driven with a one-cycle pulse and with a pin held high across a take. A level-sensitive latch there would re-raise the request after it was taken. The repurposed pins are checked for a single low cycle on the right acknowledge, and for forgetting an edge that arrived while they were outputs.

// File: rtl/irqfe_pkg.sv
package irqfe_pkg;

   typedef enum logic {
      TRIG_EDGE  = 1'b0,
      TRIG_LEVEL = 1'b1
   } trig_e;

   function automatic logic rise_of(input logic now_v, input logic was_v);
      return now_v & ~was_v;
   endfunction

endpackage

// File: rtl/irqfe_sync.sv
module irqfe_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q,
   output logic rise
);
   import irqfe_pkg::*;

   if (STAGES < 2) begin : g_bad_stages
      $error("irqfe_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         chain_q <= '0;
         prev_q  <= 1'b0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], d};
         prev_q  <= chain_q[STAGES-1];
      end
   end

   assign q    = chain_q[STAGES-1];
   assign rise = rise_of(chain_q[STAGES-1], prev_q);

endmodule

// File: rtl/irqfe_nmi.sv
module irqfe_nmi #(
   parameter int VEC_W   = 8,
   parameter int NMI_VEC = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rise,
   input  logic             boundary,
   output logic             pend,
   output logic             take,
   output logic [VEC_W-1:0] vec
);
   localparam logic [VEC_W-1:0] VEC_VAL = VEC_W'(NMI_VEC);

   if (NMI_VEC < 0 || NMI_VEC >= (1 << VEC_W)) begin : g_bad_vec
      $error("irqfe_nmi: NMI_VEC does not fit in VEC_W bits");
   end

   logic pend_q;
   logic pend_d;

   always_comb begin
      pend_d = pend_q;
      if (boundary) pend_d = 1'b0;
      if (rise)     pend_d = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) pend_q <= 1'b0;
      else        pend_q <= pend_d;
   end

   assign pend = pend_q;
   assign take = boundary & pend_q;
   assign vec  = take ? VEC_VAL : '0;

   // R3: a take without a coinciding new edge leaves the flag clear
   a_r3_take_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !rise) |=> !pend);

   // R2: a pending request survives until a boundary comes
   a_r2_hold_until_boundary: assert property (@(posedge clk) disable iff (!rst_n)
      (pend && !boundary) |=> pend);

endmodule

// File: rtl/irqfe_line.sv
module irqfe_line (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl,
   input  logic out_mode,
   input  logic sync_q,
   input  logic rise,
   input  logic ack_hit,
   output logic pend
);
   import irqfe_pkg::*;

   trig_e mode;
   logic  latch_q;
   logic  latch_d;

   assign mode = lvl ? TRIG_LEVEL : TRIG_EDGE;

   always_comb begin
      latch_d = latch_q;
      if (ack_hit) latch_d = 1'b0;
      if (rise)    latch_d = 1'b1;
      if (out_mode || mode == TRIG_LEVEL) latch_d = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) latch_q <= 1'b0;
      else        latch_q <= latch_d;
   end

   always_comb begin
      if (out_mode)                pend = 1'b0;
      else if (mode == TRIG_LEVEL) pend = sync_q;
      else                         pend = latch_q;
   end

   // R5: an edge-mode flag holds without its own acknowledge
   a_r5_edge_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!lvl && !out_mode && pend && !ack_hit) |=> (pend || lvl || out_mode));

   // R5: an edge-mode flag only rises after a synchronized edge
   a_r5_edge_needs_rise: assert property (@(posedge clk) disable iff (!rst_n)
      (!lvl && !out_mode && !pend) |=> (!pend || lvl || out_mode || $past(rise)));

endmodule

// File: rtl/irqfe_ack_drv.sv
module irqfe_ack_drv #(
   parameter int ACK_LINES = 2,
   parameter int IDX_W     = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [ACK_LINES-1:0] cfg_ack_out,
   input  logic                 ack_valid,
   input  logic [IDX_W-1:0]     ack_idx,
   output logic [ACK_LINES-1:0] ack_n
);
   logic [ACK_LINES-1:0] ack_n_q;

   for (genvar k = 0; k < ACK_LINES; k++) begin : g_drv
      localparam logic [IDX_W-1:0] LINE = IDX_W'(k);
      logic hit;

      assign hit = ack_valid && cfg_ack_out[k] && (ack_idx == LINE);

      always_ff @(posedge clk) begin
         if (!rst_n) ack_n_q[k] <= 1'b1;
         else        ack_n_q[k] <= ~hit;
      end

      // R9: a low strobe is always caused by a matching acknowledge
      a_r9_from_ack: assert property (@(posedge clk) disable iff (!rst_n)
         !ack_n_q[k] |-> $past(ack_valid && ack_idx == LINE && cfg_ack_out[k]));
   end

   assign ack_n = ack_n_q;

endmodule

// File: rtl/irq_front_end.sv
module irq_front_end #(
   parameter int NUM_IRQ     = 4,
   parameter int ACK_LINES   = 2,
   parameter int SYNC_STAGES = 2,
   parameter int VEC_W       = 8,
   parameter int NMI_VEC     = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       nmi_pin,
   input  logic [NUM_IRQ-1:0]         irq_pin,
   input  logic [NUM_IRQ-1:0]         cfg_level,
   input  logic [ACK_LINES-1:0]       cfg_ack_out,
   input  logic                       boundary,
   input  logic                       ack_valid,
   input  logic [$clog2(NUM_IRQ)-1:0] ack_idx,
   output logic                       nmi_pending,
   output logic                       nmi_take,
   output logic [VEC_W-1:0]           nmi_vector,
   output logic [NUM_IRQ-1:0]         irq_pending,
   output logic [ACK_LINES-1:0]       ack_n,
   output logic [ACK_LINES-1:0]       ack_oe
);
   localparam int IDX_W    = $clog2(NUM_IRQ);
   localparam int ACK_BASE = NUM_IRQ - ACK_LINES;

   if (NUM_IRQ < 2) begin : g_bad_num
      $error("irq_front_end: NUM_IRQ must be at least 2");
   end
   if (ACK_LINES < 1 || ACK_BASE < ACK_LINES) begin : g_bad_ack
      $error("irq_front_end: repurposed pins must not overlap the lines they acknowledge");
   end

   // non-maskable path
   logic nmi_sync;
   logic nmi_rise;

   irqfe_sync #(.STAGES(SYNC_STAGES)) u_nmi_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (nmi_pin),
      .q    (nmi_sync),
      .rise (nmi_rise)
   );

   irqfe_nmi #(.VEC_W(VEC_W), .NMI_VEC(NMI_VEC)) u_nmi (
      .clk     (clk),
      .rst_n   (rst_n),
      .rise    (nmi_rise),
      .boundary(boundary),
      .pend    (nmi_pending),
      .take    (nmi_take),
      .vec     (nmi_vector)
   );

   // maskable lines
   logic [NUM_IRQ-1:0] line_sync;
   logic [NUM_IRQ-1:0] line_rise;
   logic [NUM_IRQ-1:0] line_out;
   logic [NUM_IRQ-1:0] line_ack;

   for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
      localparam logic [IDX_W-1:0] SELF = IDX_W'(i);

      if (i >= ACK_BASE) begin : g_turnable
         assign line_out[i] = cfg_ack_out[i-ACK_BASE];
      end else begin : g_fixed
         assign line_out[i] = 1'b0;
      end

      assign line_ack[i] = ack_valid && (ack_idx == SELF);

      irqfe_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk  (clk),
         .rst_n(rst_n),
         .d    (irq_pin[i]),
         .q    (line_sync[i]),
         .rise (line_rise[i])
      );

      irqfe_line u_line (
         .clk     (clk),
         .rst_n   (rst_n),
         .lvl     (cfg_level[i]),
         .out_mode(line_out[i]),
         .sync_q  (line_sync[i]),
         .rise    (line_rise[i]),
         .ack_hit (line_ack[i]),
         .pend    (irq_pending[i])
      );
   end

   // acknowledge drivers on the repurposed pins
   irqfe_ack_drv #(.ACK_LINES(ACK_LINES), .IDX_W(IDX_W)) u_ack (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_ack_out(cfg_ack_out),
      .ack_valid  (ack_valid),
      .ack_idx    (ack_idx),
      .ack_n      (ack_n)
   );

   assign ack_oe = cfg_ack_out;

   // R8: a repurposed line never reports a request
   for (genvar k = 0; k < ACK_LINES; k++) begin : g_chk_out
      a_r8_out_quiet: assert property (@(posedge clk) disable iff (!rst_n)
         cfg_ack_out[k] |-> !irq_pending[k+ACK_BASE]);
   end

endmodule

// File: tb/irq_front_end_tb.sv
`timescale 1ns/1ps
module irq_front_end_tb;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       nmi_pin;
   logic [3:0] irq_pin;
   logic [3:0] cfg_level;
   logic [1:0] cfg_ack_out;
   logic       boundary;
   logic       ack_valid;
   logic [1:0] ack_idx;
   logic       nmi_pending;
   logic       nmi_take;
   logic [7:0] nmi_vector;
   logic [3:0] irq_pending;
   logic [1:0] ack_n;
   logic [1:0] ack_oe;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   irq_front_end u_dut (
      .clk(clk), .rst_n(rst_n), .nmi_pin(nmi_pin), .irq_pin(irq_pin),
      .cfg_level(cfg_level), .cfg_ack_out(cfg_ack_out), .boundary(boundary),
      .ack_valid(ack_valid), .ack_idx(ack_idx), .nmi_pending(nmi_pending),
      .nmi_take(nmi_take), .nmi_vector(nmi_vector), .irq_pending(irq_pending),
      .ack_n(ack_n), .ack_oe(ack_oe)
   );

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic ack(input int idx);
      ack_idx   = 2'(idx);
      ack_valid = 1'b1;
      tick(1);
      ack_valid = 1'b0;
   endtask

   initial begin
      #(200000 * 5);
      errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      rst_n = 1'b0; nmi_pin = 1'b0; irq_pin = '0; cfg_level = '0;
      cfg_ack_out = '0; boundary = 1'b0; ack_valid = 1'b0; ack_idx = '0;
      tick(3);
      // R10 reset state
      chk("R10 irq_pending", irq_pending, 0);
      chk("R10 nmi_pending", nmi_pending, 0);
      chk("R10 nmi_take", nmi_take, 0);
      chk("R10 ack_n", ack_n, 3);
      rst_n = 1'b1;
      tick(2);

      // sweep all lines in both modes
      for (int i = 0; i < 4; i++) begin
         for (int m = 0; m < 2; m++) begin
            cfg_level  = m ? 4'(1 << i) : 4'd0;
            irq_pin[i] = 1'b1;
            tick(2);
            chk("R1 arrival", irq_pending[i], m);
            tick(1);
            chk(m ? "R4 follow" : "R5 set", irq_pending[i], 1);
            irq_pin[i] = 1'b0;
            tick(3);
            chk(m ? "R4 lost" : "R5 held", irq_pending[i], m ? 0 : 1);
            ack((i + 1) % 4);
            chk("R6 other ack", irq_pending[i], m ? 0 : 1);
            ack(i);
            chk("R5 cleared", irq_pending[i], 0);
            chk("R9 idle high", ack_n, 3);
            chk("R1 others quiet", irq_pending & ~4'(1 << i), 0);
         end
      end

      // R7 edge and acknowledge at the same edge
      cfg_level  = '0;
      irq_pin[1] = 1'b1;
      tick(2);
      ack(1);
      chk("R7 set wins", irq_pending[1], 1);
      irq_pin[1] = 1'b0;
      tick(1);
      ack(1);
      chk("R7 later clear", irq_pending[1], 0);

      // R8 / R9 repurposed pins
      cfg_level   = 4'b1000;
      cfg_ack_out = 2'b11;
      irq_pin     = 4'b1100;
      tick(4);
      chk("R8 pending masked", irq_pending[3:2], 0);
      chk("R8 oe", ack_oe, 3);
      ack(0);
      chk("R9 strobe 0", ack_n, 2'b10);
      tick(1);
      chk("R9 one cycle", ack_n, 3);
      ack(1);
      chk("R9 strobe 1", ack_n, 2'b01);
      tick(1);
      chk("R9 one cycle", ack_n, 3);
      ack(2);
      chk("R9 no strobe for line 2", ack_n, 3);
      cfg_ack_out = 2'b01;
      ack(1);
      chk("R9 disabled pin stays high", ack_n, 3);
      irq_pin     = '0;
      cfg_ack_out = '0;
      tick(4);
      chk("R8 edge not remembered", irq_pending, 0);

      // R2 / R3 non-maskable path
      nmi_pin = 1'b1;
      tick(1);
      nmi_pin = 1'b0;
      tick(1);
      chk("R2 not yet", nmi_pending, 0);
      tick(1);
      chk("R2 one-cycle pulse", nmi_pending, 1);
      tick(3);
      chk("R2 holds", nmi_pending, 1);
      cfg_level   = 4'hF;
      cfg_ack_out = 2'b11;
      boundary    = 1'b1;
      #1;
      chk("R3 take", nmi_take, 1);
      chk("R3 vector", nmi_vector, 2);
      tick(1);
      boundary = 1'b0;
      #1;
      chk("R3 cleared", nmi_pending, 0);
      chk("R3 take ends", nmi_take, 0);
      chk("R3 vector zero", nmi_vector, 0);
      nmi_pin = 1'b1;
      tick(3);
      chk("R3 new edge", nmi_pending, 1);
      boundary = 1'b1;
      tick(1);
      boundary = 1'b0;
      tick(5);
      chk("R3 held pin no re-arm", nmi_pending, 0);
      boundary = 1'b1;
      #1;
      chk("R3 no take without pending", nmi_take, 0);
      boundary = 1'b0;
      nmi_pin  = 1'b0;
      tick(2);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule